// File: doc/BRIEF.md
# BPSK Byte Frame Transmitter

This block turns one byte at a time into a stream of 10-bit samples for a DAC, using antipodal (binary phase) signalling around a fixed DC level. A byte comes in through a valid/ready handshake. The block then emits one sample per strobe of a sample-rate tick input.

Each frame is built in this order:

- a single full-scale marker sample that tells the far end a byte is starting;
- an even-parity bit;
- the eight data bits, most significant first.

Every bit occupies eight samples. Those samples are drawn from a small symmetric pulse shape. The shape is added to the DC level for a one and subtracted from it for a zero.

A two-bit attenuation input sets the signal energy by right-shifting the pulse shape. The value is captured when the byte is accepted. Once the last data bit has gone out, the output settles back to the DC level and stays there until the next byte arrives. The host sees `busy` high for the whole frame. It may offer a new byte as soon as `in_ready` returns high.

Top module: `bpsk_frame_tx`

## Requirements
- R1: After synchronous reset, `dac_out` is 256 (0x100), `in_ready` is 1 and `busy` is 0.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` is 0 and `busy` is 1, and `dac_out` stays at 256 until the first tick. `in_valid` asserted while `busy` is 1 is ignored and does not alter the frame in progress.
- R3: The first tick after acceptance drives `dac_out` to 1023 (0x3FF), the sync marker.
- R4: Ticks 2 to 9 of the frame carry the parity bit. Its value is the XOR of the eight data bits, so that the nine bits together hold an even number of ones.
- R5: Ticks 10 to 73 carry the data bits, bit 7 first and bit 0 last, with each bit lasting exactly eight ticks.
- R6: Within a bit, sample k (k = 0..7) uses the pulse value 0, 32, 64, 96, 96, 64, 32, 0. A one gives 256 plus the scaled value; a zero gives 256 minus it.
- R7: The attenuation value s (0 to 3) right-shifts the pulse value by s places before it is added or subtracted. Value 1 shifts by one, 2 by two, 3 by three, and 0 leaves the pulse unchanged.
- R8: Attenuation is captured at acceptance. Changes to `atten` during a frame have no effect on its samples.
- R9: Tick 74 of a frame drives `dac_out` back to 256. From the cycle after that tick, `busy` is 0 and `in_ready` is 1, and ticks while idle keep `dac_out` at 256.
- R10: `dac_out` changes only on a clock edge where `tick` is 1, and it advances by exactly one frame sample per such edge, including when `tick` stays high for consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate strobe; one output sample per cycle it is high |
| in_valid | input | 1 | Byte offered by the host |
| in_ready | output | 1 | Block idle and able to accept a byte |
| in_data | input | 8 | Byte to transmit |
| atten | input | 2 | Pulse right-shift amount, captured at acceptance |
| dac_out | output | 10 | Unsigned sample for the DAC |
| busy | output | 1 | Frame in progress |

## Verification
The embedded properties take `tick`, `in_valid`, `in_data` and `atten` to be synchronous to `clk`, and take reset to be held for at least one edge before use. They place no limit on how often `tick` fires or on when `atten` moves.

The bench changes every input only on the falling edge, well clear of the sampling edge. It runs all 256 byte values, with gaps between ticks of zero, one and two cycles. It scrambles `atten` and offers a conflicting byte while frames are running. This exercises the ignore and capture rules without leaving those input assumptions.

// File: rtl/bpsk_tx_pkg.sv
`timescale 1ns/1ps
package bpsk_tx_pkg;

    localparam int SAMPLES_PER_BIT = 8;
    localparam int PHASE_W         = $clog2(SAMPLES_PER_BIT);
    localparam int WAVE_W          = 8;
    localparam int ATTN_W          = 2;
    localparam logic [WAVE_W-1:0] WAVE_STEP = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_BITS,
        ST_TAIL
    } frame_state_e;

    typedef enum logic [1:0] {
        SEL_MID,
        SEL_SYNC,
        SEL_WAVE
    } out_sel_e;

    typedef struct packed {
        logic                polarity;
        logic [PHASE_W-1:0]  phase;
        logic [ATTN_W-1:0]   shift;
    } wave_req_t;

    // Symmetric ramp: rises for the first half of a bit, falls for the second.
    function automatic logic [WAVE_W-1:0] wave_lut(input logic [PHASE_W-1:0] k);
        logic [PHASE_W-1:0] fold;
        fold = k[PHASE_W-1] ? ~k : k;
        return WAVE_W'(fold) * WAVE_STEP;
    endfunction

endpackage

// File: rtl/bpsk_wave_shaper.sv
`timescale 1ns/1ps
module bpsk_wave_shaper
    import bpsk_tx_pkg::*;
#(
    parameter int SAMP_W  = 10,
    parameter int MIDLINE = 256
) (
    input  wave_req_t          req,
    output logic [SAMP_W-1:0]  sample
);
    localparam logic [SAMP_W-1:0] MID = SAMP_W'(MIDLINE);

    logic [WAVE_W-1:0] raw;
    logic [WAVE_W-1:0] scaled;

    always_comb begin
        raw    = wave_lut(req.phase);
        scaled = WAVE_W'($signed(raw) >>> req.shift);
        sample = req.polarity ? (MID + SAMP_W'(scaled)) : (MID - SAMP_W'(scaled));
    end
endmodule

// File: rtl/bpsk_frame_ctrl.sv
`timescale 1ns/1ps
module bpsk_frame_ctrl
    import bpsk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [ATTN_W-1:0]  atten,
    output logic               in_ready,
    output logic               busy,
    output out_sel_e           sel,
    output wave_req_t          req
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0]   LAST_BIT   = CNT_W'(FRAME_W - 1);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SAMPLES_PER_BIT - 1);

    frame_state_e        state_q;
    logic [FRAME_W-1:0]  frame_q;
    logic [CNT_W-1:0]    bit_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [ATTN_W-1:0]   shift_q;
    logic                accept;

    assign accept = in_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            bit_q   <= '0;
            phase_q <= '0;
            shift_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_SYNC;
                    frame_q <= {^in_data, in_data};
                    shift_q <= atten;
                    bit_q   <= '0;
                    phase_q <= '0;
                end
                ST_SYNC: if (tick) state_q <= ST_BITS;
                ST_BITS: if (tick) begin
                    if (phase_q == LAST_PHASE) begin
                        phase_q <= '0;
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        if (bit_q == LAST_BIT) state_q <= ST_TAIL;
                        else                   bit_q   <= bit_q + 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                ST_TAIL: if (tick) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_SYNC: sel = SEL_SYNC;
            ST_BITS: sel = SEL_WAVE;
            default: sel = SEL_MID;
        endcase
        req.polarity = frame_q[FRAME_W-1];
        req.phase    = phase_q;
        req.shift    = shift_q;
    end

    assign in_ready = (state_q == ST_IDLE);
    assign busy     = !in_ready;

    // R8
    atten_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(shift_q));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BITS && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/bpsk_frame_tx.sv
`timescale 1ns/1ps
module bpsk_frame_tx
    import bpsk_tx_pkg::*;
#(
    parameter int SAMP_W  = 10,
    parameter int MIDLINE = 256,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [ATTN_W-1:0]  atten,
    output logic [SAMP_W-1:0]  dac_out,
    output logic               busy
);
    localparam logic [SAMP_W-1:0] MID = SAMP_W'(MIDLINE);

    out_sel_e            sel;
    wave_req_t           req;
    logic [SAMP_W-1:0]   wave_sample;
    logic [SAMP_W-1:0]   dac_q;

    bpsk_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .atten    (atten),
        .in_ready (in_ready),
        .busy     (busy),
        .sel      (sel),
        .req      (req)
    );

    bpsk_wave_shaper #(.SAMP_W(SAMP_W), .MIDLINE(MIDLINE)) u_shaper (
        .req    (req),
        .sample (wave_sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= MID;
        end else if (tick) begin
            case (sel)
                SEL_SYNC: dac_q <= '1;
                SEL_WAVE: dac_q <= wave_sample;
                default:  dac_q <= MID;
            endcase
        end
    end

    assign dac_out = dac_q;

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(dac_out));

    // R9
    idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_out == MID));

    // R3
    sync_full_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == SEL_SYNC) |=> (dac_out == '1));

    // R6
    wave_side_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == SEL_WAVE) |=> (req.polarity ? (dac_out >= MID) : (dac_out <= MID)));

    // R2
    accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready && dac_out == MID));
endmodule

// File: tb/test_bpsk_frame_tx.sv
`timescale 1ns/1ps
module test_bpsk_frame_tx;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       in_valid;
    logic [7:0] in_data;
    logic [1:0] atten;
    logic       in_ready;
    logic [9:0] dac_out;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bpsk_frame_tx i_bpsk_frame_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .atten    (atten),
        .dac_out  (dac_out),
        .busy     (busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected sample at tick t (0-based) of a frame.
    function automatic int exp_val(input logic [7:0] d, input int att, input int t);
        int idx, k, fold, w;
        logic b;
        if (t == 0)  return 1023;
        if (t == 73) return 256;
        idx  = (t - 1) / 8;
        k    = (t - 1) % 8;
        b    = (idx == 0) ? ^d : d[8 - idx];
        fold = (k < 4) ? k : 7 - k;
        w    = (fold * 32) >> att;
        return b ? 256 + w : 256 - w;
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [1:0] att,
                             input int gap, input bit poke);
        int    prev;
        string tag;
        while (!in_ready) @(negedge clk);
        chk("R2 ready before accept", in_ready, 1);
        in_valid = 1'b1;
        in_data  = d;
        atten    = att;
        @(negedge clk);
        // R8: scramble attenuation; R2: offer a conflicting byte while busy
        in_valid = poke;
        in_data  = ~d;
        atten    = ~att;
        chk("R2 busy after accept", busy, 1);
        chk("R2 ready low after accept", in_ready, 0);
        chk("R2 output quiet before tick", dac_out, 256);
        for (int t = 0; t < 74; t++) begin
            tick = 1'b1;
            @(negedge clk);
            if (t == 0) in_valid = 1'b0;
            if (t == 0)       tag = "R3 sync";
            else if (t <= 8)  tag = "R4 R6 R7 R8 parity";
            else if (t < 73)  tag = "R5 R6 R7 R8 data";
            else              tag = "R9 tail";
            chk(tag, dac_out, exp_val(d, att, t));
            if (t < 73) chk("R2 ready held low", in_ready, 0);
            else        chk("R9 ready after tail", in_ready, 1);
            prev = dac_out;
            for (int g = 0; g < gap; g++) begin
                tick = 1'b0;
                @(negedge clk);
                chk("R10 hold without tick", dac_out, prev);
            end
        end
        tick = 1'b0;
    endtask

    task automatic idle_ticks();
        for (int i = 0; i < 3; i++) begin
            tick = 1'b1;
            @(negedge clk);
            chk("R9 idle tick", dac_out, 256);
            chk("R9 idle ready", in_ready, 1);
        end
        tick = 1'b0;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        tick     = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        atten    = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 reset dac", dac_out, 256);
        chk("R1 reset ready", in_ready, 1);
        chk("R1 reset busy", busy, 0);
        idle_ticks();
        for (int d = 0; d < 256; d++) begin
            run_frame(8'(d), 2'(d % 4), d % 3, (d % 5) == 0);
            if (d % 16 == 0) idle_ticks();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule